// File: doc/BRIEF.md
# Multi-Channel Timer / PWM Generator

A bank of identical down-counting timers sits behind a small 32-bit register port with byte addresses and word-sized accesses. Each channel runs either as a periodic timer that raises an interrupt status bit on every expiry, or as a pulse-width generator whose output spends one programmed number of clock cycles low and a second programmed number high, repeating for as long as it is enabled.

Every channel owns a five-word register window holding its low-time load value, a live count readout, its control word, a clear-on-read status port and a raw status port. The high-time load values are held apart from those windows, in a packed bank of one word per channel. A read-only version word sits between the channel windows and that bank. Software programs both load values, then writes the control word with the enable bit set. The channel then starts from a fresh load, beginning with the low phase.

Top module: `tmr_pwm_bank`

## Requirements
- R1: Register map (byte offsets, accesses with addr[1:0] != 0 miss and read 0): channel k window at k*0x14 with low load +0x00, live count +0x04, control +0x08, status clear +0x0C, raw status +0x10; version at 0xAC; high load for channel k at 0xB0 + 4*k. Load and control registers read back what was written, and unmapped words read 0.
- R2: After reset every register reads 0 and all pwm and irq outputs are low.
- R3: Control bits are en = bit0, reload = bit1, irq mask = bit2, pwm = bit3. With en, reload and pwm set, the output is low for the low load count of cycles starting in the cycle after the enabling write, then high for the high load count, and repeats with that period.
- R4: A load value of 0 gives a phase of one cycle.
- R5: Clearing en drives the pwm output low in the cycle after the write and stops the counter.
- R6: A load write while the channel runs does not change the phase in progress. The new value applies at the next reload of that phase.
- R7: Raw status (bit0 at +0x10) is set when the count expires at the end of the high phase in PWM mode, or at each expiry in timer mode.
- R8: A read of +0x0C returns the status and clears it.
- R9: irq_o[k] is the status bit gated by the mask bit. A masked channel still sets its status.
- R10: In timer mode (pwm = 0) with reload set, the status sets every max(low,1) cycles. With reload clear, the counter free-runs from all ones, and the status sets every 2^CNT_W cycles.
- R11: Read data is registered. It appears in the cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pwm_o | output | NUM_CH | Per-channel PWM outputs |
| irq_o | output | NUM_CH | Per-channel masked interrupts |

## Verification
Inside each channel, assertions check on every cycle that the counter steps down by one between reloads, that a phase changes only on expiry, enable or disable, and that the status rises only after an expiry. At the top level, an assertion checks that read data holds when no read is made. Only the bench's scenarios can show the exact waveform shape for each pair of load values, the zero-as-one rule, the deferred effect of a mid-run load write, the clear-on-read path, and the free-run period. The bench sweeps every low/high pair from 0 to 4 on every channel and compares the output and irq each cycle against a period computed arithmetically.

// File: rtl/tmr_pwm_pkg.sv
package tmr_pwm_pkg;
  localparam int unsigned WIN_WORDS = 5;   // channel window: 0x14 bytes
  localparam int unsigned W_LOW     = 0;
  localparam int unsigned W_CNT     = 1;
  localparam int unsigned W_CTRL    = 2;
  localparam int unsigned W_CLR     = 3;
  localparam int unsigned W_STAT    = 4;
  localparam int unsigned VER_WORD  = 'hAC >> 2;
  localparam int unsigned HI_WORD0  = 'hB0 >> 2;

  typedef struct packed {
    logic pwm;
    logic mask;
    logic reload;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tmr_pwm_dec.sv
module tmr_pwm_dec
  import tmr_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] hit_low_o,
  output logic [NUM_CH-1:0] hit_cnt_o,
  output logic [NUM_CH-1:0] hit_ctrl_o,
  output logic [NUM_CH-1:0] hit_clr_o,
  output logic [NUM_CH-1:0] hit_stat_o,
  output logic [NUM_CH-1:0] hit_high_o,
  output logic              hit_ver_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              ok;
  logic [WORD_W-1:0] word;

  assign ok        = valid_i && (addr_i[1:0] == 2'b00);
  assign word      = addr_i[ADDR_W-1:2];
  assign hit_ver_o = ok && (word == WORD_W'(VER_WORD));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int unsigned BASE = k * WIN_WORDS;
    assign hit_low_o[k]  = ok && (word == WORD_W'(BASE + W_LOW));
    assign hit_cnt_o[k]  = ok && (word == WORD_W'(BASE + W_CNT));
    assign hit_ctrl_o[k] = ok && (word == WORD_W'(BASE + W_CTRL));
    assign hit_clr_o[k]  = ok && (word == WORD_W'(BASE + W_CLR));
    assign hit_stat_o[k] = ok && (word == WORD_W'(BASE + W_STAT));
    assign hit_high_o[k] = ok && (word == WORD_W'(HI_WORD0 + k));
  end
endmodule

// File: rtl/tmr_pwm_chan.sv
module tmr_pwm_chan
  import tmr_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_low_i,
  input  logic             wr_high_i,
  input  logic             wr_ctrl_i,
  input  logic             rd_clr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  ctrl_t            wctrl_i,
  output logic [CNT_W-1:0] low_o,
  output logic [CNT_W-1:0] high_o,
  output logic [CNT_W-1:0] cnt_o,
  output ctrl_t            ctrl_o,
  output logic             stat_o,
  output logic             pwm_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] low_q, high_q, cnt_q;
  ctrl_t            ctrl_q;
  logic             phase_q;   // 0 = low phase, 1 = high phase
  logic             stat_q;
  logic             start, expire;

  function automatic logic [CNT_W-1:0] reload_val(input logic [CNT_W-1:0] v,
                                                  input logic user);
    if (!user)          return '1;
    else if (v == '0)   return '0;   // zero counts as one cycle
    else                return v - 1'b1;
  endfunction

  assign start  = wr_ctrl_i && wctrl_i.en && !ctrl_q.en;
  assign expire = ctrl_q.en && !start && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      high_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_low_i)  low_q  <= wdata_i;
      if (wr_high_i) high_q <= wdata_i;
      if (wr_ctrl_i) ctrl_q <= wctrl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= reload_val(low_q, wctrl_i.reload);
      phase_q <= 1'b0;
    end else if (!ctrl_q.en) begin
      phase_q <= 1'b0;
    end else if (expire) begin
      if (ctrl_q.pwm && !phase_q) begin
        cnt_q   <= reload_val(high_q, ctrl_q.reload);
        phase_q <= 1'b1;
      end else begin
        cnt_q   <= reload_val(low_q, ctrl_q.reload);
        phase_q <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     stat_q <= 1'b0;
    else if (expire && (phase_q || !ctrl_q.pwm))     stat_q <= 1'b1;
    else if (rd_clr_i)                               stat_q <= 1'b0;
  end

  assign low_o  = low_q;
  assign high_o = high_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
  assign pwm_o  = ctrl_q.en && ctrl_q.pwm && phase_q;
  assign irq_o  = stat_q && !ctrl_q.mask;

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !wr_ctrl_i && cnt_q != '0) |=> $stable(phase_q));

  // R7
  stat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(ctrl_q.en && cnt_q == '0));

  // R5
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && !wctrl_i.en) |=> !pwm_o);
endmodule

// File: rtl/tmr_pwm_bank.sv
module tmr_pwm_bank
  import tmr_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] hit_low, hit_cnt, hit_ctrl, hit_clr, hit_stat, hit_high;
  logic              hit_ver, rd;
  logic [CNT_W-1:0]  low_v  [NUM_CH];
  logic [CNT_W-1:0]  high_v [NUM_CH];
  logic [CNT_W-1:0]  cnt_v  [NUM_CH];
  ctrl_t             ctrl_v [NUM_CH];
  logic [NUM_CH-1:0] stat_v;
  logic [31:0]       rdata_d, rdata_q;

  assign rd = bus_valid_i && !bus_write_i;

  tmr_pwm_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .valid_i    (bus_valid_i),
    .addr_i     (bus_addr_i),
    .hit_low_o  (hit_low),
    .hit_cnt_o  (hit_cnt),
    .hit_ctrl_o (hit_ctrl),
    .hit_clr_o  (hit_clr),
    .hit_stat_o (hit_stat),
    .hit_high_o (hit_high),
    .hit_ver_o  (hit_ver)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    tmr_pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_low_i  (hit_low[k]  && bus_write_i),
      .wr_high_i (hit_high[k] && bus_write_i),
      .wr_ctrl_i (hit_ctrl[k] && bus_write_i),
      .rd_clr_i  (hit_clr[k]  && !bus_write_i),
      .wdata_i   (bus_wdata_i[CNT_W-1:0]),
      .wctrl_i   (ctrl_t'(bus_wdata_i[3:0])),
      .low_o     (low_v[k]),
      .high_o    (high_v[k]),
      .cnt_o     (cnt_v[k]),
      .ctrl_o    (ctrl_v[k]),
      .stat_o    (stat_v[k]),
      .pwm_o     (pwm_o[k]),
      .irq_o     (irq_o[k])
    );
  end

  always_comb begin
    rdata_d = hit_ver ? VERSION : '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (hit_low[k])  rdata_d |= 32'(low_v[k]);
      if (hit_high[k]) rdata_d |= 32'(high_v[k]);
      if (hit_cnt[k])  rdata_d |= 32'(cnt_v[k]);
      if (hit_ctrl[k]) rdata_d |= 32'(ctrl_v[k]);
      if (hit_clr[k] || hit_stat[k]) rdata_d |= 32'(stat_v[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(bus_rdata_o));

  initial begin
    // R1
    map_fit_chk: assert (NUM_CH * WIN_WORDS <= VER_WORD && CNT_W <= 32 && CNT_W > 0);
  end
endmodule

// File: tb/tmr_pwm_bank_bench.sv
`timescale 1ns/1ps
module tmr_pwm_bank_bench;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam logic [31:0] VER = 32'h0001_0200;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_pwm_bank #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(8), .VERSION(VER)) u_tmr_pwm_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pwm_o(pwm), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = 8'(a); wdata = 32'(d); write = 1'b1; valid = 1'b1;
    @(posedge clk); #1;
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 8'(a); write = 1'b0; valid = 1'b1;
    @(posedge clk); #1 valid = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == 32'(exp), req, d, exp);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(pwm == '0, "R2", pwm, 0);
    chk(irq == '0, "R2", irq, 0);
    rd_chk(8'h08, 0, "R2");
    rd_chk(8'h14, 0, "R2");
    rd_chk(8'hB4, 0, "R2");
    rd_chk(8'h04, 0, "R2");

    // R1 map and readback
    rd_chk(8'hAC, int'(VER), "R1");
    wr(8'h28, 8'h5A); wr(8'hB8, 8'hC3); wr(8'h30, 4'h4);
    rd_chk(8'h28, 8'h5A, "R1");
    rd_chk(8'hB8, 8'hC3, "R1");
    rd_chk(8'h30, 4'h4, "R1");
    rd_chk(8'h29, 0, "R1");
    rd_chk(8'hA4, 0, "R1");
    rd_chk(8'hBC, 0, "R1");
    // R11 rdata holds across writes
    rd(8'hB8, d);
    wr(8'h28, 8'h11);
    @(negedge clk);
    chk(rdata == 32'hC3, "R11", rdata, 32'hC3);

    // R3 R4 R7 R9 R5 R8 sweep
    for (int ch = 0; ch < NCH; ch++) begin
      for (int lo = 0; lo <= 4; lo++) begin
        for (int hi = 0; hi <= 4; hi++) begin
          int el, eh, per;
          el = (lo == 0) ? 1 : lo;
          eh = (hi == 0) ? 1 : hi;
          per = el + eh;
          wr(ch * 20, lo);
          wr(8'hB0 + ch * 4, hi);
          wr(ch * 20 + 8, 4'hB);
          for (int t = 0; t < 2 * per; t++) begin
            @(negedge clk);
            chk(pwm[ch] == ((t % per) >= el), "R3/R4 pwm", pwm[ch], (t % per) >= el);
            chk(irq[ch] == (t >= per), "R7/R9 irq", irq[ch], t >= per);
            chk((pwm & ~(NCH'(1) << ch)) == '0, "R3 other", pwm, 0);
          end
          wr(ch * 20 + 8, 4'hA);
          @(negedge clk);
          chk(pwm[ch] == 1'b0, "R5", pwm[ch], 0);
          rd_chk(ch * 20 + 12, 1, "R8 clr");
          rd_chk(ch * 20 + 16, 0, "R8 stat");
        end
      end
    end

    // R5 counter stops
    wr(8'h14, 50); wr(8'h1C, 4'h3);
    repeat (3) @(negedge clk);
    wr(8'h1C, 4'h2);
    rd(8'h18, d);
    repeat (4) @(negedge clk);
    rd_chk(8'h18, int'(d), "R5 cnt held");

    // R6 mid-run load write
    wr(8'h14, 6); wr(8'hB4, 2); wr(8'h1C, 4'hB);
    @(negedge clk); chk(pwm[1] == 1'b0, "R6", pwm[1], 0);
    @(negedge clk); chk(pwm[1] == 1'b0, "R6", pwm[1], 0);
    wr(8'h14, 2);
    for (int t = 2; t < 12; t++) begin
      bit e;
      e = (t >= 6 && t < 8) || (t >= 10);
      @(negedge clk);
      chk(pwm[1] == e, "R6", pwm[1], e);
    end
    wr(8'h1C, 4'hA); rd(8'h20, d);

    // R10 timer mode with reload
    wr(8'h28, 5); wr(8'h30, 4'h3);
    for (int t = 0; t < 7; t++) begin
      @(negedge clk);
      chk(irq[2] == (t >= 5), "R10 timer", irq[2], t >= 5);
      chk(pwm[2] == 1'b0, "R10 no pwm", pwm[2], 0);
    end
    wr(8'h30, 4'h2); rd(8'h34, d);
    // R1 live count: enable edge loads 199, read sees it next edge
    wr(8'h28, 200); wr(8'h30, 4'h3);
    rd_chk(8'h2C, 199, "R1 cnt");
    wr(8'h30, 4'h2); rd(8'h34, d);

    // R10 free-run
    wr(8'h3C, 3); wr(8'h44, 4'h1);
    for (int t = 0; t <= 256; t++) begin
      @(negedge clk);
      if (t >= 254) chk(irq[3] == (t >= 256), "R10 free", irq[3], t >= 256);
    end
    wr(8'h44, 4'h0); rd(8'h48, d);

    // R9 masked
    wr(8'h00, 1); wr(8'hB0, 1); wr(8'h08, 4'hF);
    repeat (6) begin
      @(negedge clk);
      chk(irq[0] == 1'b0, "R9 mask", irq[0], 0);
    end
    wr(8'h08, 4'hE);
    rd_chk(8'h10, 1, "R9 stat");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule